// File: doc/BRIEF.md
# Banked Host Register Window with Packet Buffer Pointer

This block is the byte-wide host-side register window of a network controller. A host reaches sixteen byte addresses through read and write strobes with a 4-bit offset. Offset 14 is a bank selector. It picks which of four register banks the other offsets map to, and offset 15 is a fixed identification byte. The banks hold the transmit and receive control words, the configuration, general-purpose and control words, a 16-bit buffer pointer, an early-receive threshold, and several read-only identification constants.

Bank 2 holds a four-byte data port into the packet buffer. The buffer memory sits outside this block, and the block produces a byte address for it. That address is a page index joined to an in-page byte offset. The page index comes from one of two side inputs, the packet-number value or the head of the receive queue, and a pointer flag chooses between them. A second pointer flag selects auto-increment mode. In that mode every data-port access uses the pointer offset directly and then advances it by one. Without it, the pointer offset stays fixed and the low two bits of the port offset are added to it.

Setting the soft-reset bit of the receive control word returns every register in the window to its reset value. The same write produces a one-cycle pulse so that the rest of the controller can reset too.

Top module: `nic_host_regs`

## Requirements
- R1: A write to offset 14 stores wdata[1:0] as the bank, in any bank. Offset 14 reads {6'b0, bank}. Offset 15 reads 0x33 in every bank, and writes to it have no effect.
- R2: After reset the following hold: bank = 0, configuration word = 0xA0B1, control word = 0x1210, early-receive threshold = 0x1F, and the transmit control, receive control, general-purpose and pointer words = 0. soft_rst_o and both memory strobes are low.
- R3: Each 16-bit register reads back what was written, one byte at a time: the low byte at the even offset and the high byte at the odd offset. The registers are: bank 0 offsets 0/1 transmit control and 4/5 receive control; bank 1 offsets 0/1 configuration and 10/11 general purpose; bank 2 offsets 6/7 pointer. Bank 3 offset 12 is the early-receive threshold, which keeps only wdata[4:0] and reads it back zero-extended.
- R4: A data-port access is a read or write at bank 2, offsets 8 to 11. When pointer bit 15 = 1 the page is rxq_head, otherwise it is pkt_num. With pointer bit 14 = 0 the in-page offset is (pointer[10:0] + offset[1:0]) mod 2048, and mem_addr = {page, in-page offset}. mem_we and mem_re mark data-port writes and reads, and a read returns mem_rdata.
- R5: With pointer bit 14 = 1, a data-port access uses pointer[10:0] as the in-page offset, whatever the port offset. The next cycle, pointer[10:0] has advanced by one mod 2048 and pointer[15:11] is unchanged. With bit 14 = 0 the pointer does not change.
- R6: Bank 2 offset 7 reads the pointer high byte ANDed with 0xF7, so bit 3 always reads 0.
- R7: A write to bank 0 offset 5 with wdata[7] = 1 (receive control bit 15) resets the whole window to its R2 values at that clock edge. soft_rst_o is high for the following cycle.
- R8: A write to bank 1 offset 12 stores the control low byte with bits 1:0 forced to 0.
- R9: The following offsets read constants and ignore writes: bank 0 offset 3 reads 0x40; bank 0 offset 8 reads the page count (4 by default); bank 3 offsets 8, 9, 10, 11 read 0x30, 0x33, 0x91, 0x33.
- R10: Any other offset reads 0. Writes to it change nothing, and accesses to it raise no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe |
| addr | input | 4 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| pkt_num | input | PAGE_W | Packet-number page from the queue block |
| rxq_head | input | PAGE_W | Receive-queue head page from the queue block |
| mem_addr | output | PAGE_W+OFF_W | Packet buffer byte address {page, offset} |
| mem_we | output | 1 | Packet buffer write strobe |
| mem_re | output | 1 | Packet buffer read strobe |
| mem_wdata | output | 8 | Packet buffer write data |
| mem_rdata | input | 8 | Packet buffer read data |
| soft_rst_o | output | 1 | One-cycle pulse after a soft reset |

## Verification
The assertions check the following on every cycle:
- the memory strobes fire only on data-port accesses;
- an auto-increment access advances the low eleven pointer bits and leaves the top five unchanged;
- a fixed-mode access leaves the pointer unchanged;
- bank writes land in the bank selector;
- offset 15 and pointer bit 3 read as their constants;
- a soft-reset write clears the bank and pointer and raises the pulse.

Only the bench scenarios can show the following:
- the page choice and the offset wrap across the 2048 boundary;
- the reset values and masks of individual registers;
- that unimplemented offsets and constant offsets really ignore writes.

// File: rtl/nic_hr_pkg.sv
// Package: shared bank encoding, reset values and fixed read bytes of the
// host register window. Assumes an 8-bit host bus and a 4-bit offset.
package nic_hr_pkg;
    typedef enum logic [1:0] {
        BK_LINK  = 2'd0,
        BK_SETUP = 2'd1,
        BK_BUF   = 2'd2,
        BK_MISC  = 2'd3
    } bank_e;

    localparam logic [3:0]  OFF_BANK     = 4'd14;
    localparam logic [3:0]  OFF_ID       = 4'd15;
    localparam logic [15:0] CFG_RST      = 16'hA0B1;
    localparam logic [15:0] CTL_RST      = 16'h1210;
    localparam logic [4:0]  ERCV_RST     = 5'h1F;
    localparam logic [7:0]  ID_BYTE      = 8'h33;
    localparam logic [7:0]  REV_BYTE     = 8'h91;
    localparam logic [7:0]  MGMT_BYTE    = 8'h30;
    localparam logic [7:0]  LINK_STAT_HI = 8'h40;
    localparam logic [7:0]  PTR_HI_MASK  = 8'hF7;
endpackage

// File: rtl/nic_hr_ptr.sv
// Module: buffer pointer register and packet buffer address generator.
// Holds the 16-bit pointer. Bit 15 selects the receive-queue head page,
// bit 14 selects auto-increment, and the low OFF_W bits are the in-page offset.
// Assumes PAGE_BYTES is a power of two no larger than 2048, so the flag bits
// stay above the offset field. Reset is synchronous and active low.
module nic_hr_ptr #(
    parameter int NPAGES     = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PAGE_W    = $clog2(NPAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    clr_n,
    input  logic                    wr_lo,
    input  logic                    wr_hi,
    input  logic [7:0]              wdata,
    input  logic                    acc,
    input  logic [1:0]              port_off,
    input  logic [PAGE_W-1:0]       pkt_num,
    input  logic [PAGE_W-1:0]       rxq_head,
    output logic [15:0]             ptr_q,
    output logic [PAGE_W+OFF_W-1:0] mem_addr
);
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;

    // Pointer update: byte writes from the host, or post-access increment.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            ptr_q <= '0;
        end else if (wr_lo) begin
            ptr_q[7:0] <= wdata;
        end else if (wr_hi) begin
            ptr_q[15:8] <= wdata;
        end else if (acc && ptr_q[14]) begin
            ptr_q[OFF_W-1:0] <= ptr_q[OFF_W-1:0] + OFF_W'(1);
        end
    end

    // Address formation: page choice and in-page offset for the current access.
    always_comb begin
        page = ptr_q[15] ? rxq_head : pkt_num;
        if (ptr_q[14]) begin
            off = ptr_q[OFF_W-1:0];
        end else begin
            off = ptr_q[OFF_W-1:0] + OFF_W'(port_off);
        end
        mem_addr = {page, off};
    end
endmodule

// File: rtl/nic_hr_rdmux.sv
// Module: read multiplexer of the host register window.
// Maps {bank, offset} to a read byte. Unmapped offsets return 0.
// Purely combinational. Assumes the caller supplies the buffer byte
// for the current data-port address on mem_rdata.
module nic_hr_rdmux
    import nic_hr_pkg::*;
#(
    parameter int NPAGES = 4
) (
    input  bank_e       bank,
    input  logic [3:0]  addr,
    input  logic [15:0] tcr,
    input  logic [15:0] rcr,
    input  logic [15:0] cfg,
    input  logic [15:0] gpw,
    input  logic [15:0] ctl,
    input  logic [15:0] ptr,
    input  logic [4:0]  ercv,
    input  logic [7:0]  mem_rdata,
    output logic [7:0]  rdata
);
    localparam logic [7:0] PAGE_CNT = 8'(NPAGES);

    // Byte selection: fixed offsets first, then the bank-specific map.
    always_comb begin
        rdata = 8'h00;
        if (addr == OFF_BANK) begin
            rdata = {6'b0, bank};
        end else if (addr == OFF_ID) begin
            rdata = ID_BYTE;
        end else begin
            unique case (bank)
                BK_LINK: begin
                    case (addr)
                        4'd0: rdata = tcr[7:0];
                        4'd1: rdata = tcr[15:8];
                        4'd3: rdata = LINK_STAT_HI;
                        4'd4: rdata = rcr[7:0];
                        4'd5: rdata = rcr[15:8];
                        4'd8: rdata = PAGE_CNT;
                        default: rdata = 8'h00;
                    endcase
                end
                BK_SETUP: begin
                    case (addr)
                        4'd0:  rdata = cfg[7:0];
                        4'd1:  rdata = cfg[15:8];
                        4'd10: rdata = gpw[7:0];
                        4'd11: rdata = gpw[15:8];
                        4'd12: rdata = ctl[7:0];
                        4'd13: rdata = ctl[15:8];
                        default: rdata = 8'h00;
                    endcase
                end
                BK_BUF: begin
                    case (addr)
                        4'd6:  rdata = ptr[7:0];
                        4'd7:  rdata = ptr[15:8] & PTR_HI_MASK;
                        4'd8, 4'd9, 4'd10, 4'd11: rdata = mem_rdata;
                        default: rdata = 8'h00;
                    endcase
                end
                BK_MISC: begin
                    case (addr)
                        4'd8:  rdata = MGMT_BYTE;
                        4'd9:  rdata = ID_BYTE;
                        4'd10: rdata = REV_BYTE;
                        4'd11: rdata = ID_BYTE;
                        4'd12: rdata = {3'b0, ercv};
                        default: rdata = 8'h00;
                    endcase
                end
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/nic_host_regs.sv
// Module: top of the banked host register window.
// Decodes byte writes into the control registers, drives the packet buffer
// data port through the pointer unit, and raises soft_rst_o after a soft reset.
// Assumes the host never asserts wr_en and rd_en in the same cycle.
// Reset is synchronous and active low. A soft reset clears the same state.
module nic_host_regs
    import nic_hr_pkg::*;
#(
    parameter int NPAGES     = 4,
    parameter int PAGE_BYTES = 2048,
    localparam int PAGE_W    = $clog2(NPAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [3:0]              addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    input  logic [PAGE_W-1:0]       pkt_num,
    input  logic [PAGE_W-1:0]       rxq_head,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    output logic                    soft_rst_o
);
    bank_e       bank_q;
    logic [15:0] tcr_q, rcr_q, cfg_q, gpw_q, ctl_q;
    logic [4:0]  ercv_q;
    logic [15:0] ptr_q;
    logic        soft_req, clr_n, dp_hit, in_bank;

    // Access decode: data-port hit, soft-reset request and combined clear.
    always_comb begin
        in_bank  = (addr != OFF_BANK) && (addr != OFF_ID);
        dp_hit   = in_bank && (bank_q == BK_BUF) && (addr[3:2] == 2'b10);
        soft_req = wr_en && in_bank && (bank_q == BK_LINK) && (addr == 4'd5) && wdata[7];
        clr_n    = rst_n && !soft_req;
        mem_we   = wr_en && dp_hit;
        mem_re   = rd_en && dp_hit;
    end

    assign mem_wdata = wdata;

    // Register writes: bank selector and the byte-addressed control words.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            bank_q <= BK_LINK;
            tcr_q  <= '0;
            rcr_q  <= '0;
            cfg_q  <= CFG_RST;
            gpw_q  <= '0;
            ctl_q  <= CTL_RST;
            ercv_q <= ERCV_RST;
        end else if (wr_en) begin
            if (addr == OFF_BANK) begin
                bank_q <= bank_e'(wdata[1:0]);
            end else if (in_bank) begin
                unique case (bank_q)
                    BK_LINK: begin
                        case (addr)
                            4'd0: tcr_q[7:0]  <= wdata;
                            4'd1: tcr_q[15:8] <= wdata;
                            4'd4: rcr_q[7:0]  <= wdata;
                            4'd5: rcr_q[15:8] <= wdata;
                            default: ;
                        endcase
                    end
                    BK_SETUP: begin
                        case (addr)
                            4'd0:  cfg_q[7:0]  <= wdata;
                            4'd1:  cfg_q[15:8] <= wdata;
                            4'd10: gpw_q[7:0]  <= wdata;
                            4'd11: gpw_q[15:8] <= wdata;
                            4'd12: ctl_q[7:0]  <= {wdata[7:2], 2'b00};
                            4'd13: ctl_q[15:8] <= wdata;
                            default: ;
                        endcase
                    end
                    BK_MISC: begin
                        if (addr == 4'd12) ercv_q <= wdata[4:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Soft-reset pulse: one cycle after the request, cleared by hard reset.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_rst_o <= 1'b0;
        else        soft_rst_o <= soft_req;
    end

    nic_hr_ptr #(.NPAGES(NPAGES), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
        .clk      (clk),
        .clr_n    (clr_n),
        .wr_lo    (wr_en && in_bank && bank_q == BK_BUF && addr == 4'd6),
        .wr_hi    (wr_en && in_bank && bank_q == BK_BUF && addr == 4'd7),
        .wdata    (wdata),
        .acc      ((wr_en || rd_en) && dp_hit),
        .port_off (addr[1:0]),
        .pkt_num  (pkt_num),
        .rxq_head (rxq_head),
        .ptr_q    (ptr_q),
        .mem_addr (mem_addr)
    );

    nic_hr_rdmux #(.NPAGES(NPAGES)) u_rdmux (
        .bank      (bank_q),
        .addr      (addr),
        .tcr       (tcr_q),
        .rcr       (rcr_q),
        .cfg       (cfg_q),
        .gpw       (gpw_q),
        .ctl       (ctl_q),
        .ptr       (ptr_q),
        .ercv      (ercv_q),
        .mem_rdata (mem_rdata),
        .rdata     (rdata)
    );
endmodule

// File: rtl/nic_host_regs_chk.sv
// Module: assertion checker for nic_host_regs, attached by bind.
// Observes ports plus the bank and pointer state. Drives nothing.
module nic_host_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [3:0]  addr,
    input logic [7:0]  wdata,
    input logic [7:0]  rdata,
    input logic        mem_we,
    input logic        mem_re,
    input logic        soft_rst_o,
    input logic [1:0]  bank,
    input logic [15:0] ptr
);
    logic dp;
    assign dp = (bank == 2'd2) && (addr[3:2] == 2'b10);

    // R1: bank write lands in the selector
    a_r1_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'd14) |=> (bank == $past(wdata[1:0])));

    // R1: identification byte at offset 15
    a_r1_id_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'd15) |-> (rdata == 8'h33));

    // R4: memory strobes only on data-port accesses
    a_r4_strobe_scope: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (dp && (wr_en || rd_en)));

    // R5: auto-increment advances offset and keeps the upper bits
    a_r5_auto_inc: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && dp && ptr[14]) |=>
        (ptr[10:0] == $past(ptr[10:0]) + 11'd1) && (ptr[15:11] == $past(ptr[15:11])));

    // R5: fixed mode leaves the pointer alone
    a_r5_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && dp && !ptr[14]) |=> $stable(ptr));

    // R6: pointer high byte bit 3 reads zero
    a_r6_ptr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bank == 2'd2 && addr == 4'd7) |-> (rdata[3] == 1'b0));

    // R7: soft reset clears state and pulses the output
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank == 2'd0 && addr == 4'd5 && wdata[7]) |=>
        (soft_rst_o && bank == 2'd0 && ptr == 16'h0));
endmodule

bind nic_host_regs nic_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .soft_rst_o (soft_rst_o),
    .bank       (bank_q),
    .ptr        (ptr_q)
);

// File: tb/nic_host_regs_test.sv
module nic_host_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic [1:0]  pkt_num = 2'd0, rxq_head = 2'd0;
    logic [12:0] mem_addr;
    logic        mem_we, mem_re, soft_rst_o;
    logic [7:0]  mem_wdata, mem_rdata;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Bench model of the buffer memory: a fixed function of the address
    assign mem_rdata = mem_addr[7:0] ^ {3'b0, mem_addr[12:8]} ^ 8'h5C;

    nic_host_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pkt_num(pkt_num), .rxq_head(rxq_head),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .soft_rst_o(soft_rst_o)
    );

    function automatic logic [7:0] model_byte(input logic [12:0] a);
        return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h5C;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    logic [12:0] cap_addr;
    logic        cap_we, cap_re;
    logic [7:0]  cap_wd;

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        #1 cap_addr = mem_addr; cap_we = mem_we; cap_wd = mem_wdata;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata; cap_addr = mem_addr; cap_re = mem_re;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Vectors: {bank[3:0], offset[3:0], write byte, expected read byte}
    localparam int NV = 16;
    localparam logic [23:0] VEC [NV] = '{
        {4'd0, 4'd0,  8'h5A, 8'h5A},   // R3 transmit control low
        {4'd0, 4'd1,  8'hC3, 8'hC3},   // R3 transmit control high
        {4'd0, 4'd4,  8'h3E, 8'h3E},   // R3 receive control low
        {4'd0, 4'd5,  8'h41, 8'h41},   // R3 receive control high, bit7 clear
        {4'd1, 4'd0,  8'h11, 8'h11},   // R3 configuration low
        {4'd1, 4'd11, 8'h77, 8'h77},   // R3 general purpose high
        {4'd1, 4'd12, 8'hFF, 8'hFC},   // R8 control low masked
        {4'd1, 4'd13, 8'h08, 8'h08},   // R3 control high
        {4'd3, 4'd12, 8'hEE, 8'h0E},   // R3 early-receive keeps 5 bits
        {4'd3, 4'd10, 8'h00, 8'h91},   // R9 revision
        {4'd3, 4'd8,  8'h12, 8'h30},   // R9 management byte
        {4'd3, 4'd9,  8'h12, 8'h33},   // R9
        {4'd0, 4'd3,  8'hFF, 8'h40},   // R9 link status high
        {4'd0, 4'd8,  8'h99, 8'h04},   // R9 page count
        {4'd0, 4'd7,  8'h55, 8'h00},   // R10 unimplemented offset
        {4'd2, 4'd15, 8'h12, 8'h33}    // R1 id byte ignores writes
    };

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 soft_rst_o", soft_rst_o, 0);
        chk("R2 mem_we", mem_we, 0);
        rst_n = 1'b1;
        rd(4'd14, v); chk("R2 bank", v, 8'h00);
        rd(4'd0, v);  chk("R2 tcr lo", v, 8'h00);
        rd(4'd5, v);  chk("R2 rcr hi", v, 8'h00);
        wr(4'd14, 8'd1);
        rd(4'd0, v);  chk("R2 cfg lo", v, 8'hB1);
        rd(4'd1, v);  chk("R2 cfg hi", v, 8'hA0);
        rd(4'd12, v); chk("R2 ctl lo", v, 8'h10);
        rd(4'd13, v); chk("R2 ctl hi", v, 8'h12);
        rd(4'd10, v); chk("R2 gp lo", v, 8'h00);
        wr(4'd14, 8'd3);
        rd(4'd12, v); chk("R2 ercv", v, 8'h1F);
        wr(4'd14, 8'd2);
        rd(4'd7, v);  chk("R2 ptr hi", v, 8'h00);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            wr(4'd14, {4'd0, VEC[i][23:20]});
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], v);
            chk($sformatf("vector %0d (R1/R3/R8/R9/R10)", i), v, VEC[i][7:0]);
        end

        // R1: bank select round trip, offset 15 write did not disturb bank
        rd(4'd14, v); chk("R1 bank after id write", v, 8'h02);
        wr(4'd14, 8'hFD);
        rd(4'd14, v); chk("R1 bank low bits", v, 8'h01);
        rd(4'd11, v); chk("R1 bank1 gp hi still", v, 8'h77);

        // R4: fixed-mode data port, packet-number page
        pkt_num = 2'd2; rxq_head = 2'd1;
        wr(4'd14, 8'd2);
        wr(4'd6, 8'h23); wr(4'd7, 8'h01);
        wr(4'd9, 8'hAB);
        chk("R4 we", cap_we, 1);
        chk("R4 addr write", cap_addr, {2'd2, 11'h124});
        chk("R4 wdata", cap_wd, 8'hAB);
        rd(4'd11, v);
        chk("R4 re", cap_re, 1);
        chk("R4 addr read", cap_addr, {2'd2, 11'h126});
        chk("R4 rdata", v, model_byte({2'd2, 11'h126}));
        rd(4'd6, v); chk("R5 fixed mode ptr lo unchanged", v, 8'h23);
        rd(4'd5, v); chk("R10 no strobe off data port", cap_re, 0);

        // R4/R6: receive-head page, offset wrap, high byte mask
        wr(4'd6, 8'hFE); wr(4'd7, 8'h8F);
        rd(4'd11, v);
        chk("R4 rx head wrap addr", cap_addr, {2'd1, 11'h001});
        rd(4'd7, v); chk("R6 ptr hi masked", v, 8'h87);

        // R5: auto-increment with wrap
        pkt_num = 2'd3;
        wr(4'd6, 8'hFF); wr(4'd7, 8'h47);
        rd(4'd8, v);
        chk("R5 inc first addr", cap_addr, {2'd3, 11'h7FF});
        rd(4'd10, v);
        chk("R5 inc wrapped addr", cap_addr, {2'd3, 11'h000});
        chk("R5 inc rdata", v, model_byte({2'd3, 11'h000}));
        wr(4'd9, 8'hC4);
        chk("R5 inc write addr", cap_addr, {2'd3, 11'h001});
        rd(4'd6, v); chk("R5 ptr lo after three", v, 8'h02);
        rd(4'd7, v); chk("R5 ptr hi upper kept", v, 8'h40);

        // R7: soft reset
        wr(4'd14, 8'd0);
        wr(4'd0, 8'h99);
        wr(4'd5, 8'h80);
        chk("R7 pulse", soft_rst_o, 1);
        @(negedge clk);
        chk("R7 pulse ends", soft_rst_o, 0);
        rd(4'd0, v);  chk("R7 tcr cleared", v, 8'h00);
        rd(4'd5, v);  chk("R7 rcr cleared", v, 8'h00);
        wr(4'd14, 8'd1);
        rd(4'd12, v); chk("R7 ctl restored", v, 8'h10);
        wr(4'd14, 8'd2);
        rd(4'd6, v);  chk("R7 ptr cleared", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule